// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Register Command Port

This block holds a joint translation table of `SETS` sets by `WAYS` ways (128 by 4 by default, 2 ways also supported). Each entry is a pair of words: a tag word with virtual page number, valid flag, global flag and address-space ID, and a frame word with the page frame number and attribute flags. Pages are 8 KB, so the set is picked by virtual address bits 19:13.

Software drives the block only through a small auxiliary-register port. It writes the two entry words, an index register and a process-ID register, then writes a command code. The commands install an entry, read one back, let the hardware choose a slot, search the addressed set for a matching tag, or strobe the micro-table invalidate output. In parallel, a combinational lookup port translates a virtual page number under the current address-space ID. When more than one way matches, the port raises an overlap flag. Installing duplicates is never checked at write time.

Top module: `tlb_cmd_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, no entry is valid (`lk_hit`, `lk_multi`, `lk_pd1` are 0) and `utlb_inv` is 0.
- R2: Register addresses: tag word 0x405, frame word 0x406, index 0x407, command 0x408, process ID 0x409. Tag word bits 12:10 and process-ID bits 30:8 read as 0, the command register reads 0, and all other bits read back as written.
- R3: Commands 1 (write) and 5 (write, no invalidate) store the tag and frame words into the entry at linear index = set × WAYS + way, taken from the low index bits, so that bits 8:2 are the set and bits 1:0 are the way for 4 ways.
- R4: `utlb_inv` is high for exactly the one cycle after a command 1 or 6 is written, and stays low after any other command, including 5.
- R5: Command 2 loads the tag and frame registers from the entry at the index, readable one clock after the command write.
- R6: Command 4 (probe) searches the set given by tag-register bits 19:13. An entry matches when its valid bit (tag bit 9) is set, its page number (bits 31:13) is equal, and either its ID (bits 7:0) is equal or its global bit (bit 8) is set. On a hit, the index register gets the linear index of the lowest matching way.
- R7: A probe with no match writes 0x80000000 to the index register.
- R8: A probe of an existing tag followed by a command 1 overwrites that entry in place, leaving a single match.
- R9: Command 3 writes the set from tag-register bits 19:13 into the index set field and a pseudo-random way into the way field, with upper bits 0. Successive commands spread over more than one way.
- R10: With process-ID bit 31 set, a lookup of `lk_vpn` that matches one way under the process ID's bits 7:0 gives `lk_hit`=1 and `lk_pd1` = that entry's frame word. A miss gives `lk_hit`=0 and `lk_pd1`=0.
- R11: With process-ID bit 31 clear, `lk_hit` and `lk_multi` are 0.
- R12: Duplicate tags are accepted on install. `lk_multi` (with `lk_hit`) is raised only when a lookup matches two or more ways.
- R13: A global entry matches a lookup under any address-space ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lk_vpn | input | 19 | Virtual page number to translate (address bits 31:13) |
| lk_hit | output | 1 | Lookup matched at least one way |
| lk_multi | output | 1 | Lookup matched two or more ways (overlap fault) |
| lk_pd1 | output | 32 | Frame word of the lowest matching way, 0 on miss |
| utlb_inv | output | 1 | One-cycle micro-table invalidate strobe |

## Verification
The checker assumes that a command is a single-cycle write of an exact code value to 0x408, so the code is compared on the whole data word. It also assumes that the register writes before a command are complete by the clock edge that samples it. The bench keeps within this by driving each register write for one full cycle from the falling edge and releasing the strobe before the next. The pseudo-random way is never predicted: only its set field, its range and its spread are checked. Every tag the bench installs differs per way inside a set, except in the deliberate duplicate case, so each expected hit is unique.

// File: rtl/tlb_pkg.sv
// Shared constants and the tag-entry type of the translation buffer.
// Assumes 8 KB pages and 32-bit virtual addresses.
package tlb_pkg;
    localparam int PG_SHIFT = 13;
    localparam int VPNW     = 32 - PG_SHIFT;

    localparam logic [11:0] A_PD0 = 12'h405;
    localparam logic [11:0] A_PD1 = 12'h406;
    localparam logic [11:0] A_IDX = 12'h407;
    localparam logic [11:0] A_CMD = 12'h408;
    localparam logic [11:0] A_PID = 12'h409;

    localparam logic [31:0] C_WRITE    = 32'd1;
    localparam logic [31:0] C_READ     = 32'd2;
    localparam logic [31:0] C_GETIDX   = 32'd3;
    localparam logic [31:0] C_PROBE    = 32'd4;
    localparam logic [31:0] C_WRITE_NI = 32'd5;
    localparam logic [31:0] C_INV      = 32'd6;

    localparam logic [31:0] MISS_FLAG = 32'h8000_0000;

    typedef struct packed {
        logic [VPNW-1:0] vpn;
        logic            valid;
        logic            glob;
        logic [7:0]      asid;
    } tag_t;

    // Pack a tag into its register word (bits 12:10 reserved as 0).
    function automatic logic [31:0] tag_to_word(input tag_t t);
        return {t.vpn, 3'b000, t.valid, t.glob, t.asid};
    endfunction

    // Extract the tag fields from a register word.
    function automatic tag_t word_to_tag(input logic [31:0] w);
        tag_t t;
        t.vpn   = w[31:PG_SHIFT];
        t.valid = w[9];
        t.glob  = w[8];
        t.asid  = w[7:0];
        return t;
    endfunction
endpackage

// File: rtl/tlb_way_lfsr.sv
// Pseudo-random way selector: an 8-bit maximal-length LFSR that steps once
// per request. Assumes WAYW is between 1 and 8.
module tlb_way_lfsr #(
    parameter int WAYW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [WAYW-1:0] way
);
    logic [7:0] state_q;

    // Advance the shift register on each request; seed is non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= 8'h01;
        else if (step)
            state_q <= {state_q[6:0], state_q[7] ^ state_q[5] ^ state_q[4] ^ state_q[3]};
    end

    assign way = state_q[WAYW-1:0];
endmodule

// File: rtl/tlb_set_match.sv
// Compares one set's ways against a page number and address-space ID.
// A way matches when valid, page numbers are equal, and the IDs are equal or
// the entry is global. Purely combinational.
module tlb_set_match
    import tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  tag_t [WAYS-1:0] way_tag,
    input  logic [VPNW-1:0] key_vpn,
    input  logic [7:0]      key_asid,
    output logic [WAYS-1:0] hits
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hits[w] = way_tag[w].valid
                       && (way_tag[w].vpn == key_vpn)
                       && (way_tag[w].glob || (way_tag[w].asid == key_asid));
    end
endmodule

// File: rtl/tlb_cmd_unit.sv
// Set-associative translation buffer driven through a register command port.
// Holds SETS x WAYS entries at linear index set*WAYS+way (WAYS a power of two,
// 2 or 4). Commands act at the clock edge that samples the command write and
// use the register contents present before that edge. Lookup is combinational.
module tlb_cmd_unit
    import tlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [11:0]     reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [VPNW-1:0] lk_vpn,
    output logic            lk_hit,
    output logic            lk_multi,
    output logic [31:0]     lk_pd1,
    output logic            utlb_inv
);
    localparam int SETW = $clog2(SETS);
    localparam int WAYW = $clog2(WAYS);
    localparam int NENT = SETS * WAYS;
    localparam int IDXW = SETW + WAYW;

    tag_t        pd0_q;
    logic [31:0] pd1_q;
    logic [31:0] idx_q;
    logic        pid_en_q;
    logic [7:0]  pid_asid_q;
    logic        utlb_inv_q;

    tag_t        ent_tag [NENT];
    logic [31:0] ent_pd1 [NENT];

    logic            cmd_wr;
    logic            is_write;
    logic [IDXW-1:0] wr_idx;
    logic [SETW-1:0] pr_set, lk_set;
    tag_t [WAYS-1:0] pr_ways, lk_ways;
    logic [WAYS-1:0] pr_hits, lk_hits;
    logic [WAYW-1:0] pr_way, lk_way, gi_way;

    // Lowest-numbered set bit of a way-hit vector.
    function automatic logic [WAYW-1:0] first_way(input logic [WAYS-1:0] h);
        logic [WAYW-1:0] r;
        r = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (h[w]) r = WAYW'(w);
        return r;
    endfunction

    assign cmd_wr   = reg_wr && (reg_addr == A_CMD);
    assign is_write = cmd_wr && ((reg_wdata == C_WRITE) || (reg_wdata == C_WRITE_NI));
    assign wr_idx   = idx_q[IDXW-1:0];
    assign pr_set   = pd0_q.vpn[SETW-1:0];
    assign lk_set   = lk_vpn[SETW-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign pr_ways[w] = ent_tag[{pr_set, WAYW'(w)}];
        assign lk_ways[w] = ent_tag[{lk_set, WAYW'(w)}];
    end

    tlb_set_match #(.WAYS(WAYS)) u_probe_match (
        .way_tag (pr_ways),
        .key_vpn (pd0_q.vpn),
        .key_asid(pd0_q.asid),
        .hits    (pr_hits)
    );

    tlb_set_match #(.WAYS(WAYS)) u_look_match (
        .way_tag (lk_ways),
        .key_vpn (lk_vpn),
        .key_asid(pid_asid_q),
        .hits    (lk_hits)
    );

    tlb_way_lfsr #(.WAYW(WAYW)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (cmd_wr && (reg_wdata == C_GETIDX)),
        .way  (gi_way)
    );

    assign pr_way = first_way(pr_hits);
    assign lk_way = first_way(lk_hits);

    // Translation outputs, gated by the enable bit of the process-ID register.
    assign lk_hit   = pid_en_q && (lk_hits != '0);
    assign lk_multi = pid_en_q && ((lk_hits & (lk_hits - WAYS'(1))) != '0);
    assign lk_pd1   = lk_hit ? ent_pd1[{lk_set, lk_way}] : 32'h0;
    assign utlb_inv = utlb_inv_q;

    // Software-visible registers and command effects on them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd0_q      <= '0;
            pd1_q      <= '0;
            idx_q      <= '0;
            pid_en_q   <= 1'b0;
            pid_asid_q <= '0;
            utlb_inv_q <= 1'b0;
        end else begin
            utlb_inv_q <= cmd_wr && ((reg_wdata == C_WRITE) || (reg_wdata == C_INV));
            if (reg_wr) begin
                case (reg_addr)
                    A_PD0: pd0_q <= word_to_tag(reg_wdata);
                    A_PD1: pd1_q <= reg_wdata;
                    A_IDX: idx_q <= reg_wdata;
                    A_PID: begin
                        pid_en_q   <= reg_wdata[31];
                        pid_asid_q <= reg_wdata[7:0];
                    end
                    default: ;
                endcase
            end
            if (cmd_wr) begin
                case (reg_wdata)
                    C_READ: begin
                        pd0_q <= ent_tag[wr_idx];
                        pd1_q <= ent_pd1[wr_idx];
                    end
                    C_GETIDX: idx_q <= 32'({pr_set, gi_way});
                    C_PROBE:  idx_q <= (pr_hits != '0) ? 32'({pr_set, pr_way}) : MISS_FLAG;
                    default: ;
                endcase
            end
        end
    end

    // Entry storage: cleared on reset, written by the two write commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                ent_tag[i] <= '0;
                ent_pd1[i] <= '0;
            end
        end else if (is_write) begin
            ent_tag[wr_idx] <= pd0_q;
            ent_pd1[wr_idx] <= pd1_q;
        end
    end

    // Combinational register read mux; the command register reads as zero.
    always_comb begin
        case (reg_addr)
            A_PD0:   reg_rdata = tag_to_word(pd0_q);
            A_PD1:   reg_rdata = pd1_q;
            A_IDX:   reg_rdata = idx_q;
            A_PID:   reg_rdata = {pid_en_q, 23'b0, pid_asid_q};
            default: reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/tlb_cmd_unit_chk.sv
// Property checker for tlb_cmd_unit, attached by bind. Assumes commands are
// single-cycle writes of exact code values to the command register.
module tlb_cmd_unit_chk #(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [11:0]              reg_addr,
    input logic [31:0]              reg_wdata,
    input logic [$clog2(SETS)-1:0]  pd0_set,
    input logic [31:0]              idx_q,
    input logic                     xlat_on,
    input logic                     lk_hit,
    input logic                     lk_multi,
    input logic                     utlb_inv
);
    localparam int SETW = $clog2(SETS);
    localparam int WAYW = $clog2(WAYS);
    localparam int IDXW = SETW + WAYW;
    localparam int NENT = SETS * WAYS;

    logic cmd_wr;
    assign cmd_wr = reg_wr && (reg_addr == 12'h408);

    // R4
    inv_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ((reg_wdata == 32'd1) || (reg_wdata == 32'd6))) |=> utlb_inv);

    // R4
    inv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inv |-> $past(cmd_wr && ((reg_wdata == 32'd1) || (reg_wdata == 32'd6))));

    // R6
    probe_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (reg_wdata == 32'd4)) |=> ((idx_q == 32'h8000_0000) || (idx_q < NENT)));

    // R9
    getidx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (reg_wdata == 32'd3)) |=>
            ((idx_q[IDXW-1:WAYW] == $past(pd0_set)) && (idx_q[31:IDXW] == '0)));

    // R11
    xlat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_on |-> (!lk_hit && !lk_multi));

    // R12
    multi_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);
endmodule

bind tlb_cmd_unit tlb_cmd_unit_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .pd0_set  (pr_set),
    .idx_q    (idx_q),
    .xlat_on  (pid_en_q),
    .lk_hit   (lk_hit),
    .lk_multi (lk_multi),
    .utlb_inv (utlb_inv)
);

// File: tb/sim_tlb_cmd_unit.sv
`timescale 1ns/1ps
module sim_tlb_cmd_unit;
    localparam int NENT = 512;
    localparam logic [11:0] PD0 = 12'h405, PD1 = 12'h406, IDX = 12'h407,
                            CMD = 12'h408, PID = 12'h409;

    logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, lk_pd1;
    logic [18:0] lk_vpn = '0;
    logic        lk_hit, lk_multi, utlb_inv;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    tlb_cmd_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pd1(lk_pd1), .utlb_inv(utlb_inv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic look(input logic [18:0] v);
        lk_vpn = v;
        #1;
    endtask

    // Entry i: set i>>2, way i&3, per-way tag so ways of a set never collide.
    function automatic logic [18:0] e_vpn(input int i);
        return {12'((i & 3) * 5 + 3), 7'(i >> 2)};
    endfunction
    function automatic logic [31:0] e_pd0(input int i);
        return {e_vpn(i), 3'b000, 1'b1, 1'b0, 8'(i)};
    endfunction
    function automatic logic [31:0] e_pd1(input int i);
        return 32'(i) * 32'h0001_3579 + 32'h00A0_0001;
    endfunction

    task automatic install(input int idx, input logic [31:0] p0, input logic [31:0] p1,
                           input logic [31:0] cmd);
        wr(PD0, p0); wr(PD1, p1); wr(IDX, 32'(idx)); wr(CMD, cmd);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] key;
        logic [3:0]  seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(PD0, d); chk("R1 pd0", d, 0);
        rd(PD1, d); chk("R1 pd1", d, 0);
        rd(IDX, d); chk("R1 idx", d, 0);
        rd(PID, d); chk("R1 pid", d, 0);
        chk("R1 utlb_inv", 32'(utlb_inv), 0);
        look(19'h0);
        chk("R1 lk_hit", 32'(lk_hit), 0);
        chk("R1 lk_pd1", lk_pd1, 0);

        // R2 register map and reserved bits
        wr(PD0, 32'hFFFF_FFFF); wr(PD1, 32'hDEAD_BEEF);
        wr(IDX, 32'h1234_5678); wr(PID, 32'hFFFF_FFFF);
        rd(PD0, d); chk("R2 pd0 readback", d, 32'hFFFF_E3FF);
        rd(PD1, d); chk("R2 pd1 readback", d, 32'hDEAD_BEEF);
        rd(IDX, d); chk("R2 idx readback", d, 32'h1234_5678);
        rd(PID, d); chk("R2 pid readback", d, 32'h8000_00FF);
        rd(CMD, d); chk("R2 cmd reads zero", d, 0);

        // R3 R4 fill every entry, alternating plain and no-invalidate writes
        for (int i = 0; i < NENT; i++) begin
            install(i, e_pd0(i), e_pd1(i), (i % 2) ? 32'd1 : 32'd5);
            chk("R4 inv strobe after write", 32'(utlb_inv), 32'(i % 2));
        end
        @(negedge clk);
        chk("R4 inv strobe one cycle", 32'(utlb_inv), 0);
        wr(CMD, 32'd6);
        chk("R4 inv-only command", 32'(utlb_inv), 1);
        wr(CMD, 32'd3);
        chk("R4 no strobe on get-index", 32'(utlb_inv), 0);

        // R5 R3 read back every entry
        for (int i = 0; i < NENT; i++) begin
            wr(IDX, 32'(i)); wr(CMD, 32'd2);
            rd(PD0, d); chk("R5 read pd0", d, e_pd0(i));
            rd(PD1, d); chk("R5 read pd1", d, e_pd1(i));
        end

        // R6 R7 probe hit for every entry, miss under a neighbour's ID
        for (int i = 0; i < NENT; i++) begin
            wr(PD0, e_pd0(i)); wr(CMD, 32'd4);
            rd(IDX, d); chk("R6 probe hit index", d, 32'(i));
            if (i % 4 == 0) begin
                wr(PD0, e_pd0(i) ^ 32'h1); wr(CMD, 32'd4);
                rd(IDX, d); chk("R7 probe miss flag", d, 32'h8000_0000);
            end
        end

        // R10 lookup of every entry under its own ID, and misses
        for (int i = 0; i < NENT; i++) begin
            wr(PID, {1'b1, 23'b0, 8'(i)});
            look(e_vpn(i));
            chk("R10 lookup hit", 32'(lk_hit), 1);
            chk("R10 lookup pd1", lk_pd1, e_pd1(i));
            chk("R12 single match", 32'(lk_multi), 0);
            if (i % 8 == 0) begin
                wr(PID, {1'b1, 23'b0, 8'(i ^ 1)});
                look(e_vpn(i));
                chk("R10 lookup miss", 32'(lk_hit), 0);
                chk("R10 miss pd1 zero", lk_pd1, 0);
            end
        end

        // R8 probe then write replaces the entry in place
        wr(PD0, e_pd0(37)); wr(PD1, 32'hCAFE_0037); wr(CMD, 32'd4); wr(CMD, 32'd1);
        wr(PID, {1'b1, 23'b0, 8'd37});
        look(e_vpn(37));
        chk("R8 overwrite pd1", lk_pd1, 32'hCAFE_0037);
        chk("R8 no duplicate", 32'(lk_multi), 0);
        wr(IDX, 32'd37); wr(CMD, 32'd2);
        rd(PD1, d); chk("R8 entry updated", d, 32'hCAFE_0037);

        // R13 global entry matches a foreign ID
        install(50, e_pd0(50) | 32'h100, e_pd1(50), 32'd5);
        wr(PID, 32'h8000_00EE);
        look(e_vpn(50));
        chk("R13 global hit", 32'(lk_hit), 1);
        chk("R13 global pd1", lk_pd1, e_pd1(50));

        // R12 duplicates accepted, flagged at lookup; R6 probe picks lowest way
        key = {12'h7FF, 7'd3, 3'b000, 1'b1, 1'b0, 8'h11};
        install(12, key, 32'h0000_1212, 32'd5);
        install(13, key, 32'h0000_1313, 32'd5);
        wr(PID, 32'h8000_0011);
        look({12'h7FF, 7'd3});
        chk("R12 duplicate hit", 32'(lk_hit), 1);
        chk("R12 duplicate multi", 32'(lk_multi), 1);
        chk("R12 lowest way pd1", lk_pd1, 32'h0000_1212);
        wr(PD0, key); wr(CMD, 32'd4);
        rd(IDX, d); chk("R6 probe lowest way", d, 32'd12);

        // R11 translation disabled
        wr(PID, 32'h0000_0011);
        look({12'h7FF, 7'd3});
        chk("R11 no hit when off", 32'(lk_hit), 0);
        chk("R11 no multi when off", 32'(lk_multi), 0);
        chk("R11 pd1 zero when off", lk_pd1, 0);

        // R9 get-index over every set
        seen = '0;
        for (int s = 0; s < 128; s++) begin
            wr(PD0, {12'h0, 7'(s), 13'h0}); wr(CMD, 32'd3);
            rd(IDX, d);
            chk("R9 set field", d >> 2, 32'(s));
            seen[d[1:0]] = 1'b1;
        end
        chk("R9 ways spread", 32'($countones(seen) > 1), 1);

        done = 1'b1;
        finish_run();
    end
endmodule